// File: doc/BRIEF.md
# Fractional 4/13 Clock Generator

This block turns a fast reference clock into a slower clock-like output. The output averages four high cycles in every thirteen reference cycles. With a 16 MHz reference this gives about 4.92 MHz. A small sequencer counts the reference cycles modulo thirteen. A decoder marks four of the thirteen counts. The output itself comes straight from a flip-flop, so downstream logic sees clean edges. Edge placement is what matters here; duty cycle is not a goal.

The sequencer uses four state bits, so three codes never occur in normal operation. If the state lands on one of them (power-up, upset), it returns to count zero on the next reference edge without outside help. A synchronous reset also forces count zero. There is no data stream through this block, only the reference clock, the reset and the generated output.

Top module: `frac_clk_gen`

## Requirements
- R1: While `rst_sync` is high at a rising edge of `clk_fast`, the next state is count 0 and `clk_frac` is 1 after that edge.
- R2: Out of reset, the count advances by one on each rising edge from 0 up to 12, and 12 is followed by 0.
- R3: A state holding any of the unused codes 13, 14 or 15 becomes count 0 on the next rising edge, and `clk_frac` is 1 after that edge. The normal sequence then continues: counts 1 and 2 give 0, and count 3 gives 1.
- R4: `clk_frac` is 1 exactly while the count is 0, 3, 6 or 9, and 0 for every other code. It is driven by a register clocked on the rising edge of `clk_fast`.
- R5: Any window of 13 consecutive cycles in normal operation contains exactly 4 cycles with `clk_frac` high.
- R6: The distances between consecutive high cycles repeat as 3, 3, 4, 3. Counted from the high at count 3, they run 3 (to count 6), 3 (to 9), 4 (to 0), 3 (to 3).
- R7: Every high phase of `clk_frac` lasts exactly one reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Reference clock; all state changes on its rising edge |
| rst_sync | input | 1 | Synchronous active-high reset to count 0 |
| clk_frac | output | 1 | Registered fractional-rate output, 4 highs per 13 cycles |

## Verification
A corrupted count shows at the output within one reference cycle. It shifts the phase of the next high. It also breaks the 3, 3, 4, 3 spacing, or changes the number of highs in the enclosing 13-cycle window. An unused code can be visible for only one cycle. If the design fails to leave it, the output stays low for longer than four cycles. The bench plants each unused code in place of count 12. It then expects the output high on the very next edge, which would otherwise be count 0 anyway. After that it expects the normal phase from then on.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;

  // True when count s is one of the PULSES slots spaced STEP apart from zero.
  function automatic logic slot_hit(input int unsigned s,
                                    input int unsigned step,
                                    input int unsigned pulses);
    return ((s % step) == 0) && ((s / step) < pulses);
  endfunction

endpackage

// File: rtl/frac_clk_seq.sv
module frac_clk_seq #(
  parameter int unsigned DEN = 13,
  parameter int unsigned SW  = $clog2(DEN)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] state_q,
  output logic [SW-1:0] state_d
);
  localparam logic [SW-1:0] LAST = SW'(DEN - 1);

  // Terminal count and every code above it fold back to zero.
  always_comb begin
    if (state_q >= LAST) state_d = '0;
    else                 state_d = state_q + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/frac_clk_decode.sv
module frac_clk_decode #(
  parameter int unsigned SW    = 4,
  parameter int unsigned NUM   = 4,
  parameter int unsigned STEP  = 3
) (
  input  logic [SW-1:0] code,
  output logic          hit
);
  logic [NUM-1:0] slot;

  for (genvar k = 0; k < NUM; k++) begin : g_slot
    localparam logic [SW-1:0] POS = SW'(k * STEP);
    assign slot[k] = (code == POS);
  end

  assign hit = |slot;
endmodule

// File: rtl/frac_clk_outreg.sv
module frac_clk_outreg #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen #(
  parameter int unsigned DEN = 13,
  parameter int unsigned NUM = 4
) (
  input  logic clk_fast,
  input  logic rst_sync,
  output logic clk_frac
);
  localparam int unsigned SW   = $clog2(DEN);
  localparam int unsigned STEP = DEN / NUM;
  localparam logic        ZERO_HIT = frac_clk_pkg::slot_hit(0, STEP, NUM);

  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  logic          hit_next;

  frac_clk_seq #(.DEN(DEN), .SW(SW)) u_seq (
    .clk     (clk_fast),
    .rst     (rst_sync),
    .state_q (state_q),
    .state_d (state_d)
  );

  // Decode the next state so the registered output lines up with state_q.
  frac_clk_decode #(.SW(SW), .NUM(NUM), .STEP(STEP)) u_dec (
    .code (state_d),
    .hit  (hit_next)
  );

  frac_clk_outreg #(.RST_VAL(ZERO_HIT)) u_oreg (
    .clk (clk_fast),
    .rst (rst_sync),
    .d   (hit_next),
    .q   (clk_frac)
  );
endmodule

// File: rtl/frac_clk_gen_chk.sv
module frac_clk_gen_chk #(
  parameter int unsigned SW   = 4,
  parameter int unsigned DEN  = 13,
  parameter int unsigned NUM  = 4,
  parameter int unsigned STEP = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [SW-1:0] state,
  input logic          out
);
  localparam logic [SW-1:0] LAST = SW'(DEN - 1);

  logic [SW:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)      gap_q <= '0;
    else if (out) gap_q <= (SW+1)'(1);
    else          gap_q <= gap_q + (SW+1)'(1);
  end

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (state == '0) && out);

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (state == LAST) |=> (state == '0));

  a_r3_recover: assert property (@(posedge clk) disable iff (rst)
    (state > LAST) |=> (state == '0) && out);

  a_r4_decode: assert property (@(posedge clk) disable iff (rst)
    out == frac_clk_pkg::slot_hit(int'(state), STEP, NUM));

  a_r6_gap_bound: assert property (@(posedge clk) disable iff (rst)
    gap_q <= (SW+1)'(STEP + 1));

  a_r7_single_high: assert property (@(posedge clk) disable iff (rst)
    out |=> !out);
endmodule

bind frac_clk_gen frac_clk_gen_chk #(.SW(SW), .DEN(DEN), .NUM(NUM), .STEP(STEP)) u_chk (
  .clk   (clk_fast),
  .rst   (rst_sync),
  .state (state_q),
  .out   (clk_frac)
);

// File: tb/frac_clk_gen_tb.sv
module frac_clk_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_frac;
  int   n_chk = 0;
  int   n_bad = 0;

  always #5 clk = ~clk;

  frac_clk_gen u_dut (.clk_fast(clk), .rst_sync(rst), .clk_frac(clk_frac));

  // {rst, expected clk_frac}: two reset cycles, counts 1..12, then 0..12.
  localparam int NV = 27;
  localparam logic [1:0] VEC [NV] = '{
    2'b11, 2'b11,
    2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00,
    2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  logic hist [131];
  int   highs [20];
  int   nh;
  int   sum;

  initial begin
    @(negedge clk);
    // Vector table: reset state (R1), count progression and decode (R2, R4).
    for (int i = 0; i < NV; i++) begin
      rst = VEC[i][1];
      step();
      chk(VEC[i][1] ? "R1 reset" : "R2/R4 sequence", int'(clk_frac), int'(VEC[i][0]));
    end

    // R1: reset in mid-cycle restarts at count 0.
    for (int i = 0; i < 5; i++) step();
    rst = 1'b1; step();
    chk("R1 mid reset", int'(clk_frac), 1);
    rst = 1'b0; step();
    chk("R1 count1 after reset", int'(clk_frac), 0);
    step(); step();
    chk("R1 count3 after reset", int'(clk_frac), 1);

    // R5, R6, R7: long run after a clean reset.
    rst = 1'b1; step();
    rst = 1'b0;
    nh = 0;
    for (int t = 1; t <= 130; t++) begin
      step();
      hist[t] = clk_frac;
      if (clk_frac) begin
        if (nh < 20) highs[nh] = t;
        nh++;
      end
    end
    for (int w = 1; w + 12 <= 130; w++) begin
      sum = 0;
      for (int j = 0; j < 13; j++) sum += int'(hist[w + j]);
      chk("R5 window count", sum, 4);
    end
    chk("R6 first high at count3", highs[0], 3);
    for (int j = 1; j < 20 && j < nh; j++)
      chk("R6 spacing", highs[j] - highs[j-1], ((j - 1) % 4 == 2) ? 4 : 3);
    for (int t = 1; t < 130; t++)
      if (hist[t]) chk("R7 one-cycle high", int'(hist[t+1]), 0);

    // R3: plant each unused code in place of count 12.
    rst = 1'b1; step();
    rst = 1'b0;
    for (int c = 13; c <= 15; c++) begin
      for (int i = 0; i < 12; i++) step();   // now at count 12
      force u_dut.u_seq.state_q = 4'(c);
      #1;
      release u_dut.u_seq.state_q;
      step();
      chk("R3 recover to count0", int'(clk_frac), 1);
      step(); chk("R3 count1", int'(clk_frac), 0);
      step(); chk("R3 count2", int'(clk_frac), 0);
      step(); chk("R3 count3", int'(clk_frac), 1);
      for (int i = 0; i < 9; i++) step();    // back to count 12
      chk("R2 count12 after recovery", int'(clk_frac), 0);
      step(); chk("R2 wrap to count0", int'(clk_frac), 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule